// File: doc/BRIEF.md
# Bit-Plane Context Formation Engine

The engine holds one code block of sign-magnitude wavelet coefficients in an internal store. When started, it finds the most significant magnitude bit present anywhere in the block. From that bit plane down to plane 0 it runs the coding passes and turns every coded binary decision into a packed 9-bit word. These words go into an output FIFO, which an arithmetic coder drains. Each word carries the decision bit, a context label derived from the neighbourhood, a type field and a last-of-block flag.

Significance, "coded in the propagation pass" and "already refined" flags sit in a dedicated flag buffer, apart from the magnitudes. Inside a bit plane, coefficients are visited in stripes of four rows, top to bottom within each column of a stripe, and columns go left to right. The significance and sign of the row directly above the current stripe come from a small two-bank line buffer that is filled while the previous stripe is coded. That row is therefore never fetched from the main flag store. The block is loaded through a simple write port while idle and is verified at 8x8.

Top module: `bpc_engine`

## Requirements
- R1: After reset `busy` and `out_valid` are low.
- R2: Coding starts at the highest bit plane in which any magnitude has a 1, and that plane gets only the cleanup pass. A block whose magnitudes are all zero produces nothing but the terminate word. A lone magnitude of 1 produces exactly ROWS*COLS+2 words.
- R3: Each word is {type[8:7], bit[6], context[5:1], last[0]}. Type 00 is a decision, 01 is a sign and 10 is control. Type 11 never appears, and the context never exceeds 18.
- R4: Every plane below the top one runs three passes in this order: propagation, refinement, cleanup. Each pass visits coefficients in stripes of four rows, going down the column of a stripe before moving to the next column.
- R5: The decision that makes a coefficient significant (bit 1 in propagation or cleanup) is followed at once by a sign word. Its bit is the sign (1 = negative). Its context is 11 plus the number of significant negative coefficients among the four direct neighbours.
- R6: Propagation codes each insignificant coefficient that has at least one significant neighbour among its eight. Cleanup codes each insignificant coefficient not coded by propagation in that plane. Both use a context equal to the count of significant neighbours among the eight (0 to 8).
- R7: Refinement codes each coefficient that was significant before the current plane. It uses context 9 on the first refinement of that coefficient and 10 on later ones.
- R8: After the last pass, one control word 9'h101 is emitted. It is the only word with the last flag set, and `busy` then drops.
- R9: Load writes and `start` pulses that arrive while `busy` is high are ignored: the stream and the stored block are unchanged.
- R10: Stalling the consumer loses, duplicates and reorders no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one coefficient (idle only) |
| ld_addr | input | ADDR_W | Coefficient index, row*COLS+col |
| ld_sign | input | 1 | Sign, 1 = negative |
| ld_mag | input | MAG_W | Magnitude |
| start | input | 1 | Begin coding the stored block |
| busy | output | 1 | Coding in progress |
| out_valid | output | 1 | Output FIFO holds a word |
| out_word | output | 9 | Head word of the output FIFO |
| out_pop | input | 1 | Consume the head word |

## Verification
Stimulus covers an all-zero block, a lone coefficient of magnitude 1, a lone corner coefficient at full scale, a checkerboard with alternating signs, a fully saturated negative block, a diagonal gradient, two rows that straddle the stripe boundary, and pseudo-random blocks. The all-zero and lone-coefficient blocks isolate the start-plane search and the cleanup-only top plane. The saturated block separates first-refinement contexts from later ones. The boundary rows show whether the line buffer supplies correct above-stripe neighbours, and the checkerboard exercises the sign-context counts. Random blocks run with both an eager and a sluggish consumer, and once more while loads and start pulses are driven during coding; these separate backpressure and ignored-input behaviour from plain ordering.

// File: rtl/bpc_pkg.sv
// Shared types and word packing for the bit-plane context engine.
// Assumes a 9-bit output word: {type[1:0], bit, context[4:0], last}.
package bpc_pkg;

    typedef enum logic [1:0] {
        WT_DEC  = 2'b00,
        WT_SIGN = 2'b01,
        WT_CTRL = 2'b10
    } wtype_e;

    typedef enum logic [1:0] {
        PASS_SP = 2'd0,
        PASS_MR = 2'd1,
        PASS_CU = 2'd2
    } pass_e;

    localparam int WORD_W = 9;
    localparam int CTX_W  = 5;

    localparam logic [CTX_W-1:0] CTX_MR_FIRST  = 5'd9;
    localparam logic [CTX_W-1:0] CTX_MR_LATER  = 5'd10;
    localparam logic [CTX_W-1:0] CTX_SIGN_BASE = 5'd11;
    localparam logic [CTX_W-1:0] CTX_MAX       = 5'd18;

    function automatic logic [WORD_W-1:0] pack_word(wtype_e t, logic b,
                                                    logic [CTX_W-1:0] c, logic last);
        return {t, b, c, last};
    endfunction

endpackage

// File: rtl/bpc_coef_ram.sv
// Coefficient store: one magnitude word and one sign bit per position.
// Assumes a single write port and a combinational read; the full sign
// vector is exposed for neighbour lookups.
module bpc_coef_ram #(
    parameter int N      = 64,
    parameter int MAG_W  = 6,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_sign,
    input  logic [MAG_W-1:0]  wr_mag,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [MAG_W-1:0]  rd_mag,
    output logic [N-1:0]      sign_vec
);

    logic [MAG_W-1:0] mag_mem [N];
    logic [N-1:0]     sign_q;

    // magnitude array write, no reset (storage)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mag_mem[wr_addr] <= wr_mag;
        end
    end

    // sign bits with reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= '0;
        end else if (wr_en) begin
            sign_q[wr_addr] <= wr_sign;
        end
    end

    assign rd_mag   = mag_mem[rd_addr];
    assign sign_vec = sign_q;

endmodule

// File: rtl/bpc_flag_buf.sv
// Per-coefficient state kept apart from the magnitudes: significant,
// coded-in-propagation (cleared per plane) and refined-at-least-once.
// Assumes one update address per cycle.
module bpc_flag_buf #(
    parameter int N      = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_vis,
    input  logic [ADDR_W-1:0] addr,
    input  logic              set_sig,
    input  logic              set_vis,
    input  logic              set_ref,
    output logic [N-1:0]      sig_vec,
    output logic [N-1:0]      vis_vec,
    output logic [N-1:0]      ref_vec
);

    logic [N-1:0] sig_q, vis_q, ref_q;

    // flag updates; block clear wins over single-bit sets
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            sig_q <= '0;
            vis_q <= '0;
            ref_q <= '0;
        end else begin
            if (set_sig) sig_q[addr] <= 1'b1;
            if (set_ref) ref_q[addr] <= 1'b1;
            if (clr_vis)      vis_q       <= '0;
            else if (set_vis) vis_q[addr] <= 1'b1;
        end
    end

    assign sig_vec = sig_q;
    assign vis_vec = vis_q;
    assign ref_vec = ref_q;

    // a coefficient becomes significant only once per block
    p_sig_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sig && !clr_all) |-> !sig_q[addr]);

    // refinement only touches coefficients already significant
    p_ref_needs_sig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ref && !clr_all) |-> sig_q[addr]);

endmodule

// File: rtl/bpc_line_buf.sv
// Two-bank line buffer holding {sign, significance} of the bottom row of
// the stripe just coded. One bank is written while the other is read.
// Assumes the caller alternates banks per stripe and clears per pass.
module bpc_line_buf #(
    parameter int COLS  = 8,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_sig,
    input  logic             wr_sign,
    input  logic             rd_bank,
    output logic [COLS-1:0]  rd_sig,
    output logic [COLS-1:0]  rd_sign
);

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            logic [COLS-1:0] sig_q;
            logic [COLS-1:0] sign_q;

            // bank storage, written only when selected
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    sig_q  <= '0;
                    sign_q <= '0;
                end else if (wr_en && (wr_bank == 1'(b))) begin
                    sig_q[wr_col]  <= wr_sig;
                    sign_q[wr_col] <= wr_sign;
                end
            end
        end
    endgenerate

    assign rd_sig  = rd_bank ? g_bank[1].sig_q  : g_bank[0].sig_q;
    assign rd_sign = rd_bank ? g_bank[1].sign_q : g_bank[0].sign_q;

    // the row being captured must never be the row being read
    p_bank_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != rd_bank));

endmodule

// File: rtl/bpc_out_fifo.sv
// Output FIFO between context formation and the arithmetic coder.
// Assumes the writer respects full; a pop while empty is ignored.
module bpc_out_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign valid   = (count != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // writer never offers a word to a full FIFO
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // a pop on an empty FIFO leaves occupancy unchanged
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !valid && !push) |=> (count == '0));

endmodule

// File: rtl/bpc_engine.sv
// Bit-plane context formation engine. Finds the top non-zero plane, then
// runs propagation / refinement / cleanup passes per plane in four-row
// stripes, packing decisions, signs and a final terminate marker into
// 9-bit words in the output FIFO.
// Assumes ROWS is a multiple of 4 and loads happen only while idle.
module bpc_engine
    import bpc_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int COLS       = 8,
    parameter int MAG_W      = 6,
    parameter int FIFO_DEPTH = 8,
    localparam int N         = ROWS * COLS,
    localparam int ADDR_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_sign,
    input  logic [MAG_W-1:0]  ld_mag,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    output logic [8:0]        out_word,
    input  logic              out_pop
);

    localparam int STRIPES = ROWS / 4;
    localparam int STR_W   = (STRIPES > 1) ? $clog2(STRIPES) : 1;
    localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int PL_W    = (MAG_W > 1) ? $clog2(MAG_W) : 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FIND, ST_RUN, ST_SIGN, ST_TERM
    } state_e;

    state_e            state_q;
    pass_e             pass_q;
    logic [PL_W-1:0]   plane_q;
    logic [STR_W-1:0]  stripe_q;
    logic [COL_W-1:0]  col_q;
    logic [1:0]        k_q;
    logic [ADDR_W-1:0] find_q;
    logic [MAG_W-1:0]  or_q;

    // storage interfaces
    logic [ADDR_W-1:0] cur_addr, rd_addr;
    logic [MAG_W-1:0]  rd_mag;
    logic [N-1:0]      sign_vec, sig_vec, vis_vec, ref_vec;
    logic [COLS-1:0]   line_sig, line_sign;
    logic              fifo_full;

    // control strobes
    logic              push;
    logic [8:0]        push_word;
    logic              set_sig, set_vis, set_ref, clr_vis, clr_all;
    logic              lb_clr, lb_wr, lb_sig;
    logic              done_coef, last_coef;

    // per-coefficient view
    int                cur_row_i;
    logic              cur_sig, cur_vis, cur_ref, cur_sign, bitv;
    logic              emit, becomes_sig;
    logic [CTX_W-1:0]  ctx_dec;
    logic [3:0]        nb_cnt;
    logic [2:0]        neg_cnt;
    logic [MAG_W-1:0]  or_next;

    function automatic logic [PL_W-1:0] msb_of(logic [MAG_W-1:0] v);
        logic [PL_W-1:0] m;
        m = '0;
        for (int b = 0; b < MAG_W; b++) begin
            if (v[b]) m = PL_W'(b);
        end
        return m;
    endfunction

    assign busy      = (state_q != ST_IDLE);
    assign cur_row_i = int'(stripe_q) * 4 + int'(k_q);
    assign cur_addr  = ADDR_W'(cur_row_i * COLS + int'(col_q));
    assign rd_addr   = (state_q == ST_FIND) ? find_q : cur_addr;
    assign cur_sig   = sig_vec[cur_addr];
    assign cur_vis   = vis_vec[cur_addr];
    assign cur_ref   = ref_vec[cur_addr];
    assign cur_sign  = sign_vec[cur_addr];
    assign bitv      = rd_mag[plane_q];
    assign or_next   = or_q | rd_mag;
    assign last_coef = (k_q == 2'd3) && (col_q == COL_W'(COLS-1))
                       && (stripe_q == STR_W'(STRIPES-1));

    bpc_coef_ram #(.N(N), .MAG_W(MAG_W), .ADDR_W(ADDR_W)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en && !busy),
        .wr_addr  (ld_addr),
        .wr_sign  (ld_sign),
        .wr_mag   (ld_mag),
        .rd_addr  (rd_addr),
        .rd_mag   (rd_mag),
        .sign_vec (sign_vec)
    );

    bpc_flag_buf #(.N(N), .ADDR_W(ADDR_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .clr_vis (clr_vis),
        .addr    (cur_addr),
        .set_sig (set_sig),
        .set_vis (set_vis),
        .set_ref (set_ref),
        .sig_vec (sig_vec),
        .vis_vec (vis_vec),
        .ref_vec (ref_vec)
    );

    bpc_line_buf #(.COLS(COLS), .COL_W(COL_W)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (lb_clr),
        .wr_en   (lb_wr),
        .wr_bank (stripe_q[0]),
        .wr_col  (col_q),
        .wr_sig  (lb_sig),
        .wr_sign (cur_sign),
        .rd_bank (~stripe_q[0]),
        .rd_sig  (line_sig),
        .rd_sign (line_sign)
    );

    bpc_out_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (push_word),
        .full  (fifo_full),
        .pop   (out_pop),
        .dout  (out_word),
        .valid (out_valid)
    );

    // neighbour significance count (8-neighbourhood) and negative count (4-neighbourhood)
    always_comb begin
        int   nr, nc;
        logic ns, ng;
        nb_cnt  = '0;
        neg_cnt = '0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                nr = cur_row_i + dr;
                nc = int'(col_q) + dc;
                ns = 1'b0;
                ng = 1'b0;
                if (!(dr == 0 && dc == 0) && nr >= 0 && nr < ROWS && nc >= 0 && nc < COLS) begin
                    if (dr == -1 && k_q == 2'd0) begin
                        ns = line_sig[COL_W'(nc)];
                        ng = line_sign[COL_W'(nc)];
                    end else begin
                        ns = sig_vec[ADDR_W'(nr * COLS + nc)];
                        ng = sign_vec[ADDR_W'(nr * COLS + nc)];
                    end
                end
                nb_cnt = nb_cnt + {3'b000, ns};
                if ((dr == 0 || dc == 0) && ns && ng) neg_cnt = neg_cnt + 3'd1;
            end
        end
    end

    // pass-specific coding decision for the current coefficient
    always_comb begin
        emit    = 1'b0;
        ctx_dec = {1'b0, nb_cnt};
        case (pass_q)
            PASS_SP: emit = !cur_sig && (nb_cnt != 4'd0);
            PASS_MR: begin
                emit    = cur_sig && !cur_vis;
                ctx_dec = cur_ref ? CTX_MR_LATER : CTX_MR_FIRST;
            end
            default: emit = !cur_sig && !cur_vis;
        endcase
        becomes_sig = emit && bitv && (pass_q != PASS_MR);
    end

    // per-state strobes for storage, line buffer and output FIFO
    always_comb begin
        push      = 1'b0;
        push_word = '0;
        set_sig   = 1'b0;
        set_vis   = 1'b0;
        set_ref   = 1'b0;
        clr_all   = 1'b0;
        lb_wr     = 1'b0;
        lb_sig    = 1'b0;
        done_coef = 1'b0;
        case (state_q)
            ST_IDLE: clr_all = start;
            ST_RUN: if (!fifo_full) begin
                push      = emit;
                push_word = pack_word(WT_DEC, bitv, ctx_dec, 1'b0);
                set_vis   = emit && (pass_q == PASS_SP);
                set_ref   = emit && (pass_q == PASS_MR);
                set_sig   = becomes_sig;
                done_coef = !becomes_sig;
                lb_wr     = !becomes_sig && (k_q == 2'd3);
                lb_sig    = cur_sig;
            end
            ST_SIGN: if (!fifo_full) begin
                push      = 1'b1;
                push_word = pack_word(WT_SIGN, cur_sign,
                                      CTX_SIGN_BASE + {2'b00, neg_cnt}, 1'b0);
                done_coef = 1'b1;
                lb_wr     = (k_q == 2'd3);
                lb_sig    = 1'b1;
            end
            ST_TERM: if (!fifo_full) begin
                push      = 1'b1;
                push_word = pack_word(WT_CTRL, 1'b0, '0, 1'b1);
            end
            default: ;
        endcase
        lb_clr  = clr_all || (done_coef && last_coef);
        clr_vis = done_coef && last_coef && (pass_q == PASS_CU) && (plane_q != '0);
    end

    // sequencing of planes, passes and scan position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pass_q   <= PASS_CU;
            plane_q  <= '0;
            stripe_q <= '0;
            col_q    <= '0;
            k_q      <= '0;
            find_q   <= '0;
            or_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_FIND;
                    find_q  <= '0;
                    or_q    <= '0;
                end
                ST_FIND: begin
                    or_q   <= or_next;
                    find_q <= find_q + 1'b1;
                    if (find_q == ADDR_W'(N-1)) begin
                        stripe_q <= '0;
                        col_q    <= '0;
                        k_q      <= '0;
                        pass_q   <= PASS_CU;
                        plane_q  <= msb_of(or_next);
                        state_q  <= (or_next == '0) ? ST_TERM : ST_RUN;
                    end
                end
                ST_RUN, ST_SIGN: begin
                    if (state_q == ST_RUN && !fifo_full && becomes_sig) begin
                        state_q <= ST_SIGN;
                    end else if (done_coef) begin
                        state_q <= ST_RUN;
                        if (!last_coef) begin
                            if (k_q != 2'd3) begin
                                k_q <= k_q + 2'd1;
                            end else begin
                                k_q <= 2'd0;
                                if (col_q != COL_W'(COLS-1)) begin
                                    col_q <= col_q + 1'b1;
                                end else begin
                                    col_q    <= '0;
                                    stripe_q <= stripe_q + 1'b1;
                                end
                            end
                        end else begin
                            k_q      <= 2'd0;
                            col_q    <= '0;
                            stripe_q <= '0;
                            case (pass_q)
                                PASS_SP: pass_q <= PASS_MR;
                                PASS_MR: pass_q <= PASS_CU;
                                default: begin
                                    if (plane_q == '0) begin
                                        state_q <= ST_TERM;
                                    end else begin
                                        plane_q <= plane_q - 1'b1;
                                        pass_q  <= PASS_SP;
                                    end
                                end
                            endcase
                        end
                    end
                end
                ST_TERM: if (!fifo_full) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // last word handed to the FIFO, kept for ordering checks
    logic [8:0] prev_word_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_word_q <= '0;
        else if (push) prev_word_q <= push_word;
    end

    p_ctx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_word[5:1] <= CTX_MAX) && (push_word[8:7] != 2'b11));

    p_sign_after_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[8:7] == WT_SIGN) |-> (prev_word_q[8:7] == WT_DEC) && prev_word_q[6]);

    p_last_only_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[0]) |-> (push_word[8:7] == WT_CTRL));

    p_ctrl_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_word[8:7] == WT_CTRL) |=> !busy);

    p_start_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state_q != ST_TERM) |=> busy);

endmodule

// File: tb/bpc_engine_bench.sv
`timescale 1ns/1ps
module bpc_engine_bench;

    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int MAG_W = 6;
    localparam int N     = ROWS * COLS;
    localparam int AW    = $clog2(N);
    localparam int MAXW  = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_sign = 1'b0;
    logic [MAG_W-1:0] ld_mag = '0;
    logic          start = 1'b0;
    logic          busy, out_valid, out_pop;
    logic [8:0]    out_word;

    int total = 0;
    int bad   = 0;

    int  m_sign [N];
    int  m_mag  [N];
    int  q_sig  [N];
    int  q_vis  [N];
    int  q_ref  [N];
    logic [8:0] exp_w [MAXW];
    logic [8:0] got_w [MAXW];
    int  exp_n, got_n;
    int  slow = 0;
    bit  collect = 1'b0;
    int  tick = 0;
    int  seed = 32'h1234_5678;

    always #5 clk = ~clk;

    bpc_engine #(.ROWS(ROWS), .COLS(COLS), .MAG_W(MAG_W), .FIFO_DEPTH(8)) u_bpc_engine (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_sign(ld_sign),
        .ld_mag(ld_mag), .start(start), .busy(busy), .out_valid(out_valid),
        .out_word(out_word), .out_pop(out_pop)
    );

    // consumer: decides pops away from the active edge, records popped words
    initial out_pop = 1'b0;
    always @(negedge clk) begin
        tick++;
        if (collect && out_valid && (slow == 0 || (tick % 3) == 0)) begin
            out_pop = 1'b1;
            if (got_n < MAXW) got_w[got_n] = out_word;
            got_n++;
        end else begin
            out_pop = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff_ffff;
    endfunction

    function automatic int nb8(int r, int c);
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                if (!(dr == 0 && dc == 0) && r+dr >= 0 && r+dr < ROWS && c+dc >= 0 && c+dc < COLS)
                    n += q_sig[(r+dr)*COLS + c+dc];
        return n;
    endfunction

    function automatic int neg4(int r, int c);
        int n = 0;
        int rr[4] = '{r-1, r+1, r, r};
        int cc[4] = '{c, c, c-1, c+1};
        for (int i = 0; i < 4; i++)
            if (rr[i] >= 0 && rr[i] < ROWS && cc[i] >= 0 && cc[i] < COLS)
                if (q_sig[rr[i]*COLS+cc[i]] != 0 && m_sign[rr[i]*COLS+cc[i]] != 0) n++;
        return n;
    endfunction

    function automatic void add_word(int t, int b, int ctx, int last);
        if (exp_n < MAXW) exp_w[exp_n] = 9'(t*128 + b*64 + ctx*2 + last);
        exp_n++;
    endfunction

    // reference: word stream computed from the requirements (R2 R4 R5 R6 R7 R8)
    function automatic void model();
        int orv = 0;
        int top = -1;
        exp_n = 0;
        for (int i = 0; i < N; i++) begin
            q_sig[i] = 0; q_vis[i] = 0; q_ref[i] = 0;
            orv |= m_mag[i];
        end
        for (int b = 0; b < MAG_W; b++) if ((orv >> b) & 1) top = b;
        for (int pl = top; pl >= 0; pl--) begin
            for (int ps = (pl == top) ? 2 : 0; ps <= 2; ps++) begin
                if (ps == 0) for (int i = 0; i < N; i++) q_vis[i] = 0;
                for (int s = 0; s < ROWS/4; s++)
                    for (int c = 0; c < COLS; c++)
                        for (int k = 0; k < 4; k++) begin
                            int r = s*4 + k;
                            int a = r*COLS + c;
                            int bv = (m_mag[a] >> pl) & 1;
                            if (ps == 1) begin
                                if (q_sig[a] != 0 && q_vis[a] == 0) begin
                                    add_word(0, bv, (q_ref[a] != 0) ? 10 : 9, 0);
                                    q_ref[a] = 1;
                                end
                            end else if (q_sig[a] == 0 &&
                                         ((ps == 0 && nb8(r, c) > 0) || (ps == 2 && q_vis[a] == 0))) begin
                                add_word(0, bv, nb8(r, c), 0);
                                if (ps == 0) q_vis[a] = 1;
                                if (bv != 0) begin
                                    q_sig[a] = 1;
                                    add_word(1, m_sign[a], 11 + neg4(r, c), 0);
                                end
                            end
                        end
            end
        end
        add_word(2, 0, 0, 1);
    endfunction

    task automatic set_pattern(input int p);
        for (int i = 0; i < N; i++) begin
            int r = i / COLS;
            int c = i % COLS;
            m_sign[i] = 0; m_mag[i] = 0;
            case (p)
                1: if (r == 3 && c == 4) m_mag[i] = 1;
                2: if (i == N-1) begin m_mag[i] = 63; m_sign[i] = 1; end
                3: begin m_mag[i] = ((r + c) % 2 == 0) ? 5 : 0; m_sign[i] = (r % 2); end
                4, 7, 9: begin m_mag[i] = rnd() % 64; m_sign[i] = rnd() % 2; end
                5: begin m_mag[i] = 63; m_sign[i] = 1; end
                6: begin m_mag[i] = (r * 8 + c) % 64; m_sign[i] = (c % 3 == 0); end
                8: if (r == 3 || r == 4) begin m_mag[i] = 3 + c; m_sign[i] = c % 2; end
                default: ;
            endcase
        end
    endtask

    task automatic load_block();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_sign = m_sign[i][0]; ld_mag = MAG_W'(m_mag[i]);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // run one coding job and compare the stream word by word
    task automatic run_case(input int id, input int slow_mode, input bit disturb);
        model();
        got_n = 0; slow = slow_mode; collect = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            for (int i = 0; i < N; i++) begin
                @(negedge clk);
                ld_en = 1'b1; ld_addr = AW'(i); ld_sign = ~m_sign[i][0];
                ld_mag = MAG_W'(63 - m_mag[i]); start = (i % 2 == 0);
            end
            @(negedge clk); ld_en = 1'b0; start = 1'b0;
        end
        while (busy || out_valid) @(negedge clk);
        repeat (3) @(negedge clk);
        collect = 1'b0;
        check(got_n == exp_n, disturb ? "R9 word count" : "R4 word count", got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n && i < MAXW; i++) begin
            logic [8:0] e = exp_w[i];
            if (e[8:7] == 2'b10)              check(got_w[i] == e, "R8 terminate", got_w[i], e);
            else if (e[8:7] == 2'b01)         check(got_w[i] == e, "R5 sign word", got_w[i], e);
            else if (e[5:1] == 9 || e[5:1] == 10) check(got_w[i] == e, "R7 refinement", got_w[i], e);
            else if (slow_mode != 0)          check(got_w[i] == e, "R10 stalled order", got_w[i], e);
            else                              check(got_w[i] == e, "R4 R6 decision", got_w[i], e);
        end
        for (int i = 0; i < got_n && i < MAXW; i++) begin
            check(got_w[i][8:7] != 2'b11 && got_w[i][5:1] <= 5'd18, "R3 field range", got_w[i], 0);
            check(got_w[i][0] == (i == got_n-1), "R8 last flag", got_w[i][0], (i == got_n-1));
        end
        if (id >= 0) $display("case %0d words=%0d", id, got_n);
    endtask

    initial begin
        #1_900_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

        // R2: all-zero block gives only the terminate word
        set_pattern(0); load_block(); run_case(0, 0, 0);
        check(got_n == 1 && got_w[0] == 9'h101, "R2 R8 empty block", got_w[0], 9'h101);

        // R2: lone magnitude 1 -> cleanup only on plane 0: N decisions + sign + terminate
        set_pattern(1); load_block(); run_case(1, 0, 0);
        check(got_n == N + 2, "R2 cleanup-only top plane", got_n, N + 2);

        set_pattern(2); load_block(); run_case(2, 0, 0);
        set_pattern(3); load_block(); run_case(3, 0, 0);
        set_pattern(4); load_block(); run_case(4, 0, 0);

        // R7: saturated block: 2N on top plane, N refinements on each of 5 lower planes, +1
        set_pattern(5); load_block(); run_case(5, 0, 0);
        check(got_n == 2*N + 5*N + 1, "R7 saturated count", got_n, 2*N + 5*N + 1);

        set_pattern(6); load_block(); run_case(6, 0, 0);
        set_pattern(7); load_block(); run_case(7, 1, 0);
        set_pattern(8); load_block(); run_case(8, 0, 0);

        // R9: loads and start during coding are ignored; stored block survives
        set_pattern(9); load_block(); run_case(9, 1, 1);
        run_case(10, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule